// File: doc/BRIEF.md
# Multichannel Receive Word Readout Sequencer

This block sits between eight ARINC 429 receive channels and a host-side parallel bus. Each channel hands over one completed 32-bit word together with a 3-bit error code. The block holds one word per channel and picks the next channel to serve by rotating priority, so that the channel served most recently drops to the bottom of the order. When a channel has been picked, the block raises `data_ready`. The host then pulls `cs_n` low and pulses `os_n` to step through the message on `dout`.

A message is sent either as three 16-bit words or as five bytes. The first unit packs the label, the two SDI bits, the 3-bit number of the channel being served and the error code. The second unit carries ARINC bits 9 to 24. The third carries bits 25 to 32 (data, SSM and parity) with a zero upper byte. Raising `cs_n` ends the access at once, whether or not every unit was read. A message that was left partly unread marks that channel with a service-overrun code, and the code is reported with the channel's next message. After an access ends, the next channel is offered only after a fixed hold-off of `GAP_CYC` clocks.

Top module: `mcrx_readout`

## Requirements
- R1: After reset, `data_ready` is 0 and `dout` is 0. When several channels are pending at the first arbitration, channel 0 is served first.
- R2: Arbitration searches upward from the channel after the one served last, wrapping from 7 to 0. The served channel's number appears in the first word at `dout[12:10]` (000 = channel 0, 111 = channel 7), and it does not change while `data_ready` stays high.
- R3: In word mode the first unit is `{err[2:0], chan[2:0], w[9:8], w[7:0]}`, where `w[0]` is ARINC bit 1. It is visible on `dout` in the cycle after `cs_n` is sampled low.
- R4: In word mode the second unit is `w[23:8]` and the third is `{8'h00, w[31:24]}`. After the third unit has been advanced past, `dout` reads 0.
- R5: With `byte_mode`=1, five bytes come out on `dout[7:0]` in the order w1[7:0], w1[15:8], w2[7:0], w2[15:8], w3[7:0], where w1 to w3 are the three word-mode units. `dout[15:8]` is always 0, and `dout` reads 0 after the fifth byte.
- R6: The output advances by one unit on each low-to-high transition of `os_n` that is sampled while an access is open (`cs_n` low). Toggling `os_n` while `cs_n` is high has no effect, so the access still starts at the first unit.
- R7: `cs_n` sampled high during an access ends it. In the next cycle `data_ready` is 0 and `dout` is 0. The channel's pending word is discarded and the channel is not offered again until it delivers a new word.
- R8: `data_ready` rises again exactly `GAP_CYC` (default 4) clock edges after the edge that ended the access, provided another channel is pending.
- R9: Ending an access before every unit was advanced past marks the channel. The channel's next message then reports error code 001 when its own code is 000. A complete read clears the mark.
- R10: A nonzero error code supplied with a word takes precedence over the service-overrun mark.
- R11: A completion pulse on a channel that already holds a pending word is ignored, and the held word is the one that is read out.
- R12: With no channel pending, `data_ready` stays 0 and `dout` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_mode | input | 1 | 1 selects five-byte readout, 0 selects three-word readout |
| rx_done | input | N_CH | One-cycle completion pulse per channel |
| rx_word | input | N_CH*32 | Completed word of each channel; channel i occupies bits [32i+31:32i] |
| rx_err | input | N_CH*3 | Error code of each channel's word; channel i occupies bits [3i+2:3i] |
| cs_n | input | 1 | Chip enable, active low; opens and ends an access |
| os_n | input | 1 | Output select strobe; a rising edge advances the output unit |
| data_ready | output | 1 | A channel has been picked and is waiting to be read or is being read |
| dout | output | 16 | Current output unit, 0 outside an access |

## Verification
All inputs are driven on the falling clock edge, and outputs are sampled on the following falling edge. The first unit therefore appears one edge after `cs_n` is driven low. Each advance lands one edge after `os_n` returns high. The drop of `data_ready` and the clearing of `dout` land one edge after `cs_n` returns high. The hold-off check counts the falling edges from that termination: `data_ready` must read 0 at the first four and 1 at the fifth. Rotation, the overrun mark and the ignored-completion cases are checked against a bench model of the pending words, which predicts the channel number and the error field of every first word.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
    localparam int WORD_W = 32;
    localparam int ERR_W  = 3;
    localparam int BUS_W  = 16;
    localparam int ID_W   = 3;
    localparam int IDX_W  = 3;
    localparam logic [ERR_W-1:0] ERR_NONE    = 3'b000;
    localparam logic [ERR_W-1:0] ERR_SVC_OVR = 3'b001;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READY,
        ST_READ,
        ST_GAP
    } rdo_state_e;
endpackage

// File: rtl/rdo_chan_store.sv
module rdo_chan_store
    import rdo_pkg::*;
#(
    parameter int N_CH = 8,
    parameter int CH_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_CH-1:0]         rx_done,
    input  logic [N_CH*WORD_W-1:0]  rx_word,
    input  logic [N_CH*ERR_W-1:0]   rx_err,
    input  logic                    clr_en,
    input  logic [CH_W-1:0]         clr_ch,
    input  logic                    clr_partial,
    input  logic [CH_W-1:0]         rd_ch,
    output logic [N_CH-1:0]         pend,
    output logic [WORD_W-1:0]       rd_word,
    output logic [ERR_W-1:0]        rd_err
);
    typedef struct packed {
        logic [N_CH-1:0]             pend;
        logic [N_CH-1:0]             ovr;
        logic [N_CH-1:0][WORD_W-1:0] word;
        logic [N_CH-1:0][ERR_W-1:0]  err;
    } store_t;

    store_t q, d;

    always_comb begin
        d = q;
        for (int i = 0; i < N_CH; i++) begin
            if (rx_done[i] && !q.pend[i]) begin
                d.pend[i] = 1'b1;
                d.word[i] = rx_word[i*WORD_W +: WORD_W];
                d.err[i]  = rx_err[i*ERR_W +: ERR_W];
            end
        end
        if (clr_en) begin
            d.pend[clr_ch] = 1'b0;
            d.ovr[clr_ch]  = clr_partial;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend    = q.pend;
    assign rd_word = q.word[rd_ch];
    assign rd_err  = (q.err[rd_ch] != ERR_NONE) ? q.err[rd_ch]
                   : (q.ovr[rd_ch] ? ERR_SVC_OVR : ERR_NONE);
endmodule

// File: rtl/rdo_rr_arb.sv
module rdo_rr_arb #(
    parameter int N_CH = 8,
    parameter int CH_W = 3
) (
    input  logic [N_CH-1:0] req,
    input  logic [CH_W-1:0] last,
    output logic            any,
    output logic [CH_W-1:0] grant
);
    logic            found;
    logic [CH_W-1:0] cand;

    always_comb begin
        any   = |req;
        grant = last;
        found = 1'b0;
        cand  = '0;
        for (int k = 1; k <= N_CH; k++) begin
            cand = CH_W'((int'(last) + k) % N_CH);
            if (!found && req[cand]) begin
                grant = cand;
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rdo_out_fmt.sv
module rdo_out_fmt
    import rdo_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic              active,
    input  logic              byte_mode,
    input  logic [IDX_W-1:0]  idx,
    input  logic [CH_W-1:0]   ch,
    input  logic [WORD_W-1:0] word,
    input  logic [ERR_W-1:0]  err,
    output logic [BUS_W-1:0]  dout
);
    logic [BUS_W-1:0] u1, u2, u3, unit;

    always_comb begin
        u1 = {err, ID_W'(ch), word[9:8], word[7:0]};
        u2 = word[23:8];
        u3 = {8'h00, word[31:24]};
        unit = '0;
        if (byte_mode) begin
            case (idx)
                3'd0:    unit = {8'h00, u1[7:0]};
                3'd1:    unit = {8'h00, u1[15:8]};
                3'd2:    unit = {8'h00, u2[7:0]};
                3'd3:    unit = {8'h00, u2[15:8]};
                3'd4:    unit = {8'h00, u3[7:0]};
                default: unit = '0;
            endcase
        end else begin
            case (idx)
                3'd0:    unit = u1;
                3'd1:    unit = u2;
                3'd2:    unit = u3;
                default: unit = '0;
            endcase
        end
        dout = active ? unit : '0;
    end
endmodule

// File: rtl/mcrx_readout.sv
module mcrx_readout
    import rdo_pkg::*;
#(
    parameter int N_CH    = 8,
    parameter int GAP_CYC = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   byte_mode,
    input  logic [N_CH-1:0]        rx_done,
    input  logic [N_CH*WORD_W-1:0] rx_word,
    input  logic [N_CH*ERR_W-1:0]  rx_err,
    input  logic                   cs_n,
    input  logic                   os_n,
    output logic                   data_ready,
    output logic [BUS_W-1:0]       dout
);
    localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam int CNT_W = $clog2(GAP_CYC + 1);

    typedef struct packed {
        rdo_state_e       st;
        logic [CH_W-1:0]  ch;
        logic [CH_W-1:0]  last;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
        logic             os_prev;
    } ctl_t;

    ctl_t q, d;

    logic [N_CH-1:0]   pend;
    logic              any;
    logic [CH_W-1:0]   grant;
    logic              clr_en, clr_partial;
    logic [WORD_W-1:0] sel_word;
    logic [ERR_W-1:0]  sel_err;
    logic [IDX_W-1:0]  n_units;
    logic              in_read;
    logic [CH_W-1:0]   sel_ch;

    rdo_chan_store #(.N_CH(N_CH), .CH_W(CH_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rx_done(rx_done), .rx_word(rx_word), .rx_err(rx_err),
        .clr_en(clr_en), .clr_ch(q.ch), .clr_partial(clr_partial),
        .rd_ch(q.ch), .pend(pend), .rd_word(sel_word), .rd_err(sel_err)
    );

    rdo_rr_arb #(.N_CH(N_CH), .CH_W(CH_W)) u_arb (
        .req(pend), .last(q.last), .any(any), .grant(grant)
    );

    always_comb begin
        d           = q;
        d.os_prev   = os_n;
        clr_en      = 1'b0;
        clr_partial = 1'b0;
        n_units     = byte_mode ? IDX_W'(5) : IDX_W'(3);
        case (q.st)
            ST_IDLE: begin
                if (any) begin
                    d.st = ST_READY;
                    d.ch = grant;
                end
            end
            ST_READY: begin
                if (!cs_n) begin
                    d.st  = ST_READ;
                    d.idx = '0;
                end
            end
            ST_READ: begin
                if (cs_n) begin
                    clr_en      = 1'b1;
                    clr_partial = (q.idx < n_units);
                    d.last      = q.ch;
                    d.st        = ST_GAP;
                    d.cnt       = CNT_W'(GAP_CYC - 1);
                end else if (!q.os_prev && os_n && (q.idx < n_units)) begin
                    d.idx = q.idx + 1'b1;
                end
            end
            ST_GAP: begin
                if (q.cnt == '0) begin
                    if (any) begin
                        d.st = ST_READY;
                        d.ch = grant;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.ch      <= '0;
            q.last    <= CH_W'(N_CH - 1);
            q.idx     <= '0;
            q.cnt     <= '0;
            q.os_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign in_read    = (q.st == ST_READ);
    assign sel_ch     = q.ch;
    assign data_ready = (q.st == ST_READY) || (q.st == ST_READ);

    rdo_out_fmt #(.CH_W(CH_W)) u_fmt (
        .active(in_read), .byte_mode(byte_mode), .idx(q.idx),
        .ch(q.ch), .word(sel_word), .err(sel_err), .dout(dout)
    );
endmodule

// File: rtl/rdo_chk.sv
module rdo_chk #(
    parameter int N_CH    = 8,
    parameter int CH_W    = 3,
    parameter int GAP_CYC = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs_n,
    input logic            byte_mode,
    input logic            data_ready,
    input logic [15:0]     dout,
    input logic            in_read,
    input logic [CH_W-1:0] sel_ch,
    input logic [N_CH-1:0] pend
);
    int unsigned since_end;
    logic        ended_once;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_end  <= 0;
            ended_once <= 1'b0;
        end else if (in_read && cs_n) begin
            since_end  <= 0;
            ended_once <= 1'b1;
        end else if (since_end < 32'hFFFF_0000) begin
            since_end <= since_end + 1;
        end
    end

    // R7
    end_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_read && cs_n |=> !data_ready && dout == 16'h0000);

    // R12
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_ready |-> dout == 16'h0000);

    // R2
    grant_is_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |-> pend[sel_ch]);

    // R2
    chan_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |=> (!data_ready || $stable(sel_ch)));

    // R5
    byte_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_mode |-> dout[15:8] == 8'h00);

    // R8
    holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) && ended_once |-> since_end >= GAP_CYC);
endmodule

bind mcrx_readout rdo_chk #(.N_CH(N_CH), .CH_W(CH_W), .GAP_CYC(GAP_CYC)) u_rdo_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_mode(byte_mode),
    .data_ready(data_ready), .dout(dout), .in_read(in_read),
    .sel_ch(sel_ch), .pend(pend)
);

// File: tb/mcrx_readout_test.sv
`timescale 1ns/1ps
module mcrx_readout_test;
    localparam int N   = 8;
    localparam int GAP = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            byte_mode = 1'b0;
    logic [N-1:0]    rx_done = '0;
    logic [N*32-1:0] rx_word = '0;
    logic [N*3-1:0]  rx_err = '0;
    logic            cs_n = 1'b1;
    logic            os_n = 1'b1;
    logic            data_ready;
    logic [15:0]     dout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [N-1:0] pm = '0;
    logic [N-1:0] ovrm = '0;
    logic [31:0]  wm [N];
    logic [2:0]   em [N];
    int           last_m = N - 1;

    mcrx_readout #(.N_CH(N), .GAP_CYC(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode),
        .rx_done(rx_done), .rx_word(rx_word), .rx_err(rx_err),
        .cs_n(cs_n), .os_n(os_n), .data_ready(data_ready), .dout(dout)
    );

    always #2.5 clk = ~clk;

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int pick_m();
        for (int k = 1; k <= N; k++) begin
            if (pm[(last_m + k) % N]) return (last_m + k) % N;
        end
        return -1;
    endfunction

    task automatic post_set(input int ch, input logic [31:0] w, input logic [2:0] e);
        rx_done[ch] = 1'b1;
        rx_word[ch*32 +: 32] = w;
        rx_err[ch*3 +: 3] = e;
        if (!pm[ch]) begin
            pm[ch] = 1'b1;
            wm[ch] = w;
            em[ch] = e;
        end
    endtask

    task automatic post_go();
        step();
        rx_done = '0;
    endtask

    task automatic wait_ready(input string tag);
        for (int i = 0; i < 64 && !data_ready; i++) step();
        chk(tag, "data_ready offered", data_ready, 1);
    endtask

    task automatic serve(input string tag, input int nread);
        int ch;
        int cnt;
        logic [2:0]  e;
        logic [15:0] w1, w2, w3;
        logic [15:0] it [5];
        ch  = pick_m();
        cnt = byte_mode ? 5 : 3;
        e   = (em[ch] != 3'b000) ? em[ch] : (ovrm[ch] ? 3'b001 : 3'b000);
        w1  = {e, 3'(ch), wm[ch][9:8], wm[ch][7:0]};
        w2  = wm[ch][23:8];
        w3  = {8'h00, wm[ch][31:24]};
        if (byte_mode) begin
            it[0] = {8'h00, w1[7:0]};  it[1] = {8'h00, w1[15:8]};
            it[2] = {8'h00, w2[7:0]};  it[3] = {8'h00, w2[15:8]};
            it[4] = {8'h00, w3[7:0]};
        end else begin
            it[0] = w1; it[1] = w2; it[2] = w3; it[3] = '0; it[4] = '0;
        end
        cs_n = 1'b0;
        step();
        if (!byte_mode) chk("R2", "port id field", {29'd0, dout[12:10]}, ch);
        for (int i = 0; i < nread; i++) begin
            chk(tag, $sformatf("unit %0d of channel %0d", i, ch), dout, it[i]);
            os_n = 1'b0;
            step();
            os_n = 1'b1;
            step();
        end
        if (nread == cnt) chk(byte_mode ? "R5" : "R4", "bus after last unit", dout, 0);
        cs_n = 1'b1;
        step();
        chk("R7", "data_ready after end", data_ready, 0);
        chk("R7", "bus after end", dout, 0);
        pm[ch]   = 1'b0;
        ovrm[ch] = (nread < cnt);
        last_m   = ch;
    endtask

    task automatic t_reset();
        chk("R1", "data_ready in reset", data_ready, 0);
        chk("R1", "dout in reset", dout, 0);
        rst_n = 1'b1;
        repeat (6) step();
        chk("R12", "data_ready with nothing pending", data_ready, 0);
        chk("R12", "dout with nothing pending", dout, 0);
    endtask

    task automatic t_priority_and_holdoff();
        post_set(3, 32'hA5C3_1E42, 3'b000);
        post_set(0, 32'h1234_5678, 3'b000);
        post_set(5, 32'hF00D_BEEF, 3'b011);
        post_go();
        wait_ready("R1");
        serve("R1", 3);
        for (int i = 0; i < GAP - 1; i++) begin
            step();
            chk("R8", "data_ready during hold-off", data_ready, 0);
        end
        step();
        chk("R8", "data_ready after hold-off", data_ready, 1);
        serve("R3", 3);
        wait_ready("R2");
        serve("R4", 3);
    endtask

    task automatic t_rotation();
        post_set(1, 32'h0BAD_CAFE, 3'b000);
        post_set(6, 32'h5555_AAAA, 3'b010);
        post_go();
        wait_ready("R2");
        serve("R2", 3);
        wait_ready("R2");
        serve("R2", 3);
    endtask

    task automatic t_bytes();
        repeat (GAP + 2) step();
        byte_mode = 1'b1;
        post_set(2, 32'h89AB_CDEF, 3'b010);
        post_go();
        wait_ready("R5");
        serve("R5", 5);
        repeat (GAP + 2) step();
        byte_mode = 1'b0;
    endtask

    task automatic t_strobe_while_idle();
        post_set(4, 32'h7E7E_0181, 3'b000);
        post_go();
        wait_ready("R6");
        for (int i = 0; i < 3; i++) begin
            os_n = 1'b0;
            step();
            os_n = 1'b1;
            step();
        end
        serve("R6", 3);
    endtask

    task automatic t_partial();
        post_set(2, 32'h1111_2222, 3'b000);
        post_go();
        wait_ready("R9");
        serve("R9", 1);
        for (int i = 0; i < 12; i++) step();
        chk("R7", "partially read channel not re-offered", data_ready, 0);
        post_set(2, 32'h3333_4444, 3'b000);
        post_go();
        wait_ready("R9");
        serve("R9", 3);
        repeat (GAP + 2) step();
        post_set(2, 32'h5555_6666, 3'b000);
        post_go();
        wait_ready("R9");
        serve("R9", 3);
        repeat (GAP + 2) step();
        post_set(4, 32'h9999_0000, 3'b000);
        post_go();
        wait_ready("R10");
        serve("R10", 2);
        repeat (GAP + 2) step();
        post_set(4, 32'hABCD_0102, 3'b011);
        post_go();
        wait_ready("R10");
        serve("R10", 3);
    endtask

    task automatic t_ignore_second();
        repeat (GAP + 2) step();
        post_set(7, 32'hCAFE_0077, 3'b000);
        post_go();
        wait_ready("R11");
        post_set(7, 32'hDEAD_0099, 3'b110);
        post_go();
        serve("R11", 3);
        repeat (GAP + 4) step();
        chk("R11", "no second offer from ignored pulse", data_ready, 0);
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        t_priority_and_holdoff();
        t_rotation();
        t_bytes();
        t_strobe_while_idle();
        t_partial();
        t_ignore_second();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule